// File: doc/BRIEF.md
# Audio Port Control/Status Register Bank

This block holds the configuration and error state of a serial audio port. The port's datapath and bit-clock generator sit outside it and read a 32-bit control word. Software reaches the bank over a single-cycle register bus with no wait states. There are two registers, control and status. Each one answers at three word addresses. A write to the plain address replaces the writable bits. A write to the set alias ORs the data in. A write to the clear alias removes the bits that are 1 in the data. With the aliases, one bit such as run can be flipped without a read-modify-write sequence.

The datapath reports three things to the bank: a busy level, an underflow pulse and an overflow pulse. The two error pulses load sticky flags in the status register. An interrupt output is high whenever the enable bit in the control register is set and either flag is held.

Two guards protect the configuration. While the reset-hold or clock-stop bit is set, only those two bits respond to writes. While the port reports busy, the format and mode fields are frozen.

Top module: `aport_csr`

## Requirements
- R1: After reset the control word reads 0xC000_0000 (bit 31 reset-hold = 1, bit 30 clock-stop = 1), both error flags read 0, and irq_o is 0.
- R2: A write to the plain address (control 0x00, status 0x10) replaces the writable control bits with the write data. The writable bits are 0 run, 1 slave, 2 receive, 3 irq enable, 5:4 word length, 8:6 clock multiplier, 9 base-384, 10 bit-clock edge, 11 frame polarity, 12 one-bit delay, 13 justify, 30 and 31. Reserved bits always read 0.
- R3: A write to base+0x4 sets exactly the bits that are 1 in the write data and leaves every other bit unchanged.
- R4: A write to base+0x8 clears exactly the bits that are 1 in the write data and leaves every other bit unchanged.
- R5: While bit 31 or bit 30 is 1 before a write, that write changes only bits 31:30. Bits 29:0 hold their values.
- R6: While busy_i is 1, bits 1, 2 and 13:4 hold their values. Run (bit 0) and irq enable (bit 3) stay writable.
- R7: Status bit 0 mirrors busy_i. Bit 1 (underflow) and bit 2 (overflow) are set by a high underflow_i or overflow_i and stay set until a 1 is written to them at 0x18. Writes at 0x10 and 0x14 do not change them.
- R8: If an error pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: irq_o is 1 exactly when control bit 3 is 1 and at least one error flag is 1. It follows those bits with no extra register stage.
- R10: Reads return the current register value at all three aliases of a register, combinationally from addr_i. Offset 0xC of either register and any unaligned address read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 5 | Byte address: bit 4 register, bits 3:2 alias |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| busy_i | input | 1 | Port active, from datapath |
| underflow_i | input | 1 | FIFO underflow event pulse |
| overflow_i | input | 1 | FIFO overflow event pulse |
| ctrl_o | output | 32 | Control word to datapath |
| irq_o | output | 1 | FIFO error interrupt |

## Verification
The main conflict is on a status flag. A hardware error pulse can set the flag in the same cycle that software writes the status clear alias with a 1 in that bit. The bench provokes this with a directed pair of cycles and also with a long random sweep. The sweep drives underflow and overflow pulses independently of the bus traffic, so clear writes collide with events at random. A second overlap is between a control write and busy_i rising in the same cycle. A reference model in the bench predicts every flag and control bit each cycle. It applies the set-wins rule and the busy freeze, and a miscompare is reported against that prediction.

// File: rtl/aport_csr_pkg.sv
package aport_csr_pkg;
  localparam int DW      = 32;
  localparam int NUM_ERR = 2;

  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } alias_op_e;

  localparam int B_RUN   = 0;
  localparam int B_IRQEN = 3;
  localparam int B_CGATE = 30;
  localparam int B_SRST  = 31;
  localparam int B_BUSY  = 0;
  localparam int ERR_LSB = 1;

  localparam logic [DW-1:0] RST_VAL   = 32'hC000_0000;
  localparam logic [DW-1:0] CORE_MASK = 32'hC000_0000;
  localparam logic [DW-1:0] LIVE_MASK = 32'h0000_0009;
  localparam logic [DW-1:0] FMT_MASK  = 32'h0000_3FF6;

  function automatic logic [DW-1:0] apply_alias(logic [DW-1:0] old_v,
                                                logic [DW-1:0] wd,
                                                alias_op_e op);
    case (op)
      OP_WR:   return wd;
      OP_SET:  return old_v | wd;
      OP_CLR:  return old_v & ~wd;
      default: return old_v;
    endcase
  endfunction
endpackage

// File: rtl/aport_csr_decode.sv
module aport_csr_decode
  import aport_csr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output alias_op_e         op_o,
  output logic              stat_sel_o,
  output logic              ctrl_we_o,
  output logic              stat_we_o
);
  localparam int REG_BIT = ADDR_W - 1;

  logic hit;

  always_comb begin
    op_o = (addr_i[1:0] == 2'b00) ? alias_op_e'(addr_i[3:2]) : OP_NONE;
    stat_sel_o = addr_i[REG_BIT];
    hit = req_i & we_i & (op_o != OP_NONE);
    ctrl_we_o = hit & ~stat_sel_o;
    stat_we_o = hit & stat_sel_o;
  end
endmodule

// File: rtl/aport_csr_ctrl.sv
module aport_csr_ctrl
  import aport_csr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  alias_op_e     op_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  output logic [DW-1:0] ctrl_o
);
  logic [DW-1:0] q, d, cand, mask;

  always_comb begin
    mask = CORE_MASK;
    // gating is judged on the value held before this write
    if (!(q[B_SRST] | q[B_CGATE])) begin
      mask |= LIVE_MASK;
      if (!busy_i) mask |= FMT_MASK;
    end
    cand = apply_alias(q, wdata_i, op_i);
    d = (q & ~mask) | (cand & mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_VAL;
    else if (we_i) q <= d;
  end

  assign ctrl_o = q;
endmodule

// File: rtl/aport_csr_stat.sv
module aport_csr_stat
  import aport_csr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  alias_op_e          op_i,
  input  logic [NUM_ERR-1:0] clr_bits_i,
  input  logic [NUM_ERR-1:0] evt_i,
  output logic [NUM_ERR-1:0] err_o
);
  logic clr_we;
  assign clr_we = we_i & (op_i == OP_CLR);

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) err_o[i] <= 1'b0;
      else         err_o[i] <= evt_i[i] | (err_o[i] & ~(clr_we & clr_bits_i[i]));
    end
  end
endmodule

// File: rtl/aport_csr.sv
module aport_csr
  import aport_csr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              busy_i,
  input  logic              underflow_i,
  input  logic              overflow_i,
  output logic [DW-1:0]     ctrl_o,
  output logic              irq_o
);
  localparam int PAD_W = DW - NUM_ERR - 1;

  alias_op_e          op;
  logic               stat_sel, ctrl_we, stat_we;
  logic [NUM_ERR-1:0] err_q, evt;

  assign evt = {overflow_i, underflow_i};

  aport_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .op_o(op), .stat_sel_o(stat_sel), .ctrl_we_o(ctrl_we), .stat_we_o(stat_we)
  );

  aport_csr_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ctrl_we), .op_i(op),
    .wdata_i(wdata_i), .busy_i(busy_i), .ctrl_o(ctrl_o)
  );

  aport_csr_stat u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(stat_we), .op_i(op),
    .clr_bits_i(wdata_i[ERR_LSB +: NUM_ERR]), .evt_i(evt), .err_o(err_q)
  );

  always_comb begin
    if (op == OP_NONE)  rdata_o = '0;
    else if (stat_sel)  rdata_o = {{PAD_W{1'b0}}, err_q, busy_i};
    else                rdata_o = ctrl_o;
  end

  assign irq_o = ctrl_o[B_IRQEN] & (|err_q);
endmodule

// File: rtl/aport_csr_chk.sv
module aport_csr_chk
  import aport_csr_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ctrl_we,
  input logic               stat_we,
  input alias_op_e          op,
  input logic               busy_i,
  input logic [DW-1:0]      ctrl_o,
  input logic [NUM_ERR-1:0] err_q,
  input logic [NUM_ERR-1:0] evt,
  input logic               irq_o
);
  p_set_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && op == OP_SET) |=> (($past(ctrl_o) & ~ctrl_o) == '0));

  p_clr_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && op == OP_CLR) |=> ((ctrl_o & ~$past(ctrl_o)) == '0));

  p_gate_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && (ctrl_o[B_SRST] || ctrl_o[B_CGATE]))
      |=> (ctrl_o[29:0] == $past(ctrl_o[29:0])));

  p_busy_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && busy_i) |=> ((ctrl_o & FMT_MASK) == ($past(ctrl_o) & FMT_MASK)));

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_we) |=> (($past(err_q) & ~err_q) == '0));

  p_evt_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |=> ((err_q & $past(evt)) == $past(evt)));

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[B_IRQEN] || err_q == '0) |-> !irq_o);
endmodule

bind aport_csr aport_csr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we(ctrl_we), .stat_we(stat_we),
  .op(op), .busy_i(busy_i), .ctrl_o(ctrl_o), .err_q(err_q), .evt(evt),
  .irq_o(irq_o)
);

// File: tb/aport_csr_test.sv
module aport_csr_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, busy = 1'b0, unf = 1'b0, ovf = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, ctrl;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_ctrl;
  logic        m_unf, m_ovf;

  always #10 clk = ~clk;

  aport_csr uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_i(busy), .underflow_i(unf),
    .overflow_i(ovf), .ctrl_o(ctrl), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [4:0] a);
    if (a[1:0] != 2'b00 || a[3:2] == 2'd3) return 32'h0;
    if (a[4]) return {29'h0, m_ovf, m_unf, busy};
    return m_ctrl;
  endfunction

  // one bus cycle plus event inputs; model updated from requirements
  task automatic step(string tag, logic w, logic [4:0] a, logic [31:0] d,
                      logic b, logic eu, logic eo);
    logic [31:0] cand, mask;
    logic clr;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; busy = b; unf = eu; ovf = eo;
    #1 chk({tag, " R10 read"}, rdata, exp_read(a));
    if (w && a[1:0] == 2'b00 && a[3:2] != 2'd3 && !a[4]) begin
      case (a[3:2])
        2'd0: cand = d;
        2'd1: cand = m_ctrl | d;
        default: cand = m_ctrl & ~d;
      endcase
      mask = 32'hC000_0000;
      if (!(m_ctrl[31] | m_ctrl[30])) mask |= b ? 32'h9 : 32'h3FFF;
      m_ctrl = (m_ctrl & ~mask) | (cand & mask);
    end
    clr = w && a == 5'h18;
    m_unf = eu | (m_unf & ~(clr & d[1]));
    m_ovf = eo | (m_ovf & ~(clr & d[2]));
    @(posedge clk);
    #1;
    chk({tag, " ctrl"}, ctrl, m_ctrl);
    chk({tag, " R9 irq"}, {31'h0, irq}, {31'h0, m_ctrl[3] & (m_unf | m_ovf)});
    @(negedge clk);
    req = 1'b0; we = 1'b0; unf = 1'b0; ovf = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    m_ctrl = 32'hC000_0000; m_unf = 1'b0; m_ovf = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1 ctrl", ctrl, 32'hC000_0000);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    step("R1 stat", 1'b0, 5'h10, 32'h0, 1'b0, 1'b0, 1'b0);
    // R5: gated, only 31:30 move
    step("R5", 1'b1, 5'h00, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    chk("R5 value", ctrl, 32'hC000_0000);
    step("R5 ungate", 1'b1, 5'h08, 32'hC000_0000, 1'b0, 1'b0, 1'b0);
    chk("R4 value", ctrl, 32'h0);
    // R2: plain write, reserved bits drop
    step("R2", 1'b1, 5'h00, 32'h3FFF_FFFF, 1'b0, 1'b0, 1'b0);
    chk("R2 value", ctrl, 32'h0000_3FFF);
    step("R4", 1'b1, 5'h08, 32'h0000_0FF0, 1'b0, 1'b0, 1'b0);
    chk("R4 value", ctrl, 32'h0000_300F);
    step("R3", 1'b1, 5'h04, 32'h0000_0030, 1'b0, 1'b0, 1'b0);
    chk("R3 value", ctrl, 32'h0000_303F);
    // R6: busy freezes format, run/irq enable still move
    step("R6", 1'b1, 5'h00, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
    chk("R6 value", ctrl, 32'h0000_3036);
    // R7: sticky flags, plain/set writes ignored
    step("R7 evt", 1'b0, 5'h10, 32'h0, 1'b0, 1'b1, 1'b1);
    step("R7 plain", 1'b1, 5'h10, 32'h0, 1'b0, 1'b0, 1'b0);
    step("R7 set", 1'b1, 5'h14, 32'h0, 1'b0, 1'b0, 1'b0);
    step("R7 rd", 1'b0, 5'h14, 32'h0, 1'b1, 1'b0, 1'b0);
    chk("R7 value", rdata, 32'h7);
    step("R9 en", 1'b1, 5'h04, 32'h8, 1'b0, 1'b0, 1'b0);
    chk("R9 value", {31'h0, irq}, 32'h1);
    // R8: clear and event collide
    step("R8", 1'b1, 5'h18, 32'h6, 1'b0, 1'b1, 1'b0);
    step("R8 rd", 1'b0, 5'h10, 32'h0, 1'b0, 1'b0, 1'b0);
    chk("R8 value", rdata, 32'h2);
    // R10: offset 0xC ignores writes
    step("R10 hole", 1'b1, 5'h0C, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    // random sweep across every alias
    for (int i = 0; i < 4000; i++) begin
      logic [4:0]  a;
      logic [31:0] d;
      string t;
      a = {$urandom_range(1, 0) == 1 ? 1'b1 : 1'b0, 2'($urandom_range(3, 0)), 2'b00};
      d = $urandom;
      if ($urandom_range(3, 0) != 0) d[31:30] = 2'b00;
      case (a[3:2])
        2'd0: t = "R2 sweep";
        2'd1: t = "R3 sweep";
        2'd2: t = "R4 sweep";
        default: t = "R10 sweep";
      endcase
      if (a[4]) t = {t, " R7"};
      step(t, $urandom_range(3, 0) != 0, a, d, $urandom_range(3, 0) == 0,
           $urandom_range(7, 0) == 0, $urandom_range(7, 0) == 0);
    end
    done = 1;
    summary();
  end
endmodule